// File: doc/BRIEF.md
# Doorbell Channel Window Pair

This block joins a sending window and a receiving window through one shared row of doorbell flags. Each flag is an independent doorbell. The sender rings doorbells by writing ones to a set register. It can read the flags back, and a transfer is finished once its flag reads zero. The receiver sees the same flags and can hide any of them behind a mask. It clears flags with write-one-to-clear writes. Clearing a flag that was raised sends a transfer-acknowledge event back to the sender.

Each side has a plain register strobe port: a write enable, a word address and write data, plus a read-data output that is decoded combinationally from the address. Each side drives its own interrupt line and a combined-interrupt line. The combined line is gated by bit 0 of that side's control register. The acknowledge event is held by a two-state machine. `ACK_IDLE` moves to `ACK_RAISED` when a pending flag is cleared. `ACK_RAISED` moves back to `ACK_IDLE` when the sender writes bit 0 of the acknowledge-clear register. If a new raise arrives in the same cycle as that clear, the machine stays in `ACK_RAISED`.

Sender word addresses: 0 flag status (read), 1 flag set (write-one), 2 acknowledge status (bit 0, read), 3 acknowledge clear (bit 0, write-one), 4 acknowledge enable (bit 0, read/write), 5 control (bit 0 combine enable). Receiver word addresses: 0 flag status, 1 masked status, 2 flag clear (write-one), 3 mask (read), 4 mask set (write-one), 5 mask clear (write-one), 6 control (bit 0 combine enable). Unmapped addresses read as 0.

Top module: `doorbell_window`

## Requirements
- R1: After reset all flags read 0, the receiver mask reads all ones, the acknowledge status, the acknowledge enable and both control bits read 0, and every interrupt output is low.
- R2: A write to sender address 1 sets each flag whose data bit is 1 and leaves every other flag unchanged.
- R3: Sender address 0 and receiver address 0 both return the current flags, one cycle after the write that changed them.
- R4: A write to receiver address 2 clears each flag whose data bit is 1 and leaves the others unchanged.
- R5: If a set and a clear hit the same flag in the same cycle, the flag ends up 1 and no acknowledge is raised for it.
- R6: Writes to receiver address 4 set mask bits and writes to receiver address 5 clear them, both write-one. Receiver address 3 reads the mask back.
- R7: Receiver address 1 returns the flags ANDed with the inverted mask, and `rx_irq` is high exactly when that value is non-zero.
- R8: Clearing at least one flag that was 1 moves the acknowledge machine to `ACK_RAISED`, so sender address 2 bit 0 reads 1. Clearing only flags that were already 0 raises nothing.
- R9: Writing 1 to bit 0 of sender address 3 returns the machine to `ACK_IDLE`, except in a cycle that also raises a new acknowledge, in which case the status stays 1.
- R10: Sender address 4 bit 0 is a read/write enable, and `tx_irq` equals acknowledge status AND that enable.
- R11: Bit 0 of each side's control register (sender address 5, receiver address 6) reads back, and that side's combined output equals its interrupt AND this bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_wen | input | 1 | Sender write strobe |
| tx_addr | input | 3 | Sender word address |
| tx_wdata | input | 32 | Sender write data |
| tx_rdata | output | 32 | Sender read data for `tx_addr` |
| tx_irq | output | 1 | Sender acknowledge interrupt |
| tx_comb_irq | output | 1 | Sender interrupt gated by combine enable |
| rx_wen | input | 1 | Receiver write strobe |
| rx_addr | input | 3 | Receiver word address |
| rx_wdata | input | 32 | Receiver write data |
| rx_rdata | output | 32 | Receiver read data for `rx_addr` |
| rx_irq | output | 1 | Receiver doorbell interrupt |
| rx_comb_irq | output | 1 | Receiver interrupt gated by combine enable |

## Verification
The bench drives a set and a clear at the same flag in one cycle. A design that let the clear win would lose the doorbell and raise a false acknowledge. It also drives an acknowledge clear in the same cycle as a fresh raise, which a design giving priority to the clear would drop. Clears of flags that are already zero check that no spurious acknowledge appears. Partial mask set and clear patterns check that masked status and `rx_irq` follow the mask bit by bit instead of treating it as a single gate.

// File: rtl/dbl_pkg.sv
package dbl_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        TX_STAT    = 3'd0,
        TX_SET     = 3'd1,
        TX_ACK_ST  = 3'd2,
        TX_ACK_CLR = 3'd3,
        TX_ACK_EN  = 3'd4,
        TX_CTRL    = 3'd5
    } tx_reg_e;

    typedef enum logic [ADDR_W-1:0] {
        RX_STAT  = 3'd0,
        RX_MSTAT = 3'd1,
        RX_CLR   = 3'd2,
        RX_MASK  = 3'd3,
        RX_MSET  = 3'd4,
        RX_MCLR  = 3'd5,
        RX_CTRL  = 3'd6
    } rx_reg_e;

    typedef enum logic {
        ACK_IDLE   = 1'b0,
        ACK_RAISED = 1'b1
    } ack_state_e;
endpackage

// File: rtl/dbl_flag_store.sv
module dbl_flag_store #(
    parameter int FLAG_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] set_bits,
    input  logic [FLAG_W-1:0] clr_bits,
    output logic [FLAG_W-1:0] flags,
    output logic              any_dropped
);
    logic [FLAG_W-1:0] flags_nxt;
    logic [FLAG_W-1:0] dropped;

    always_comb begin
        dropped   = clr_bits & flags & ~set_bits;
        flags_nxt = (flags & ~clr_bits) | set_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= '0;
        else        flags <= flags_nxt;
    end

    assign any_dropped = |dropped;

    // R2
    set_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_bits) |=> ((flags & $past(set_bits)) == $past(set_bits)));
    // R4
    clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_bits & ~set_bits)) |=> ((flags & $past(clr_bits & ~set_bits)) == '0));
endmodule

// File: rtl/dbl_rx_mask.sv
module dbl_rx_mask #(
    parameter int FLAG_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] mset_bits,
    input  logic [FLAG_W-1:0] mclr_bits,
    input  logic [FLAG_W-1:0] flags,
    output logic [FLAG_W-1:0] mask,
    output logic [FLAG_W-1:0] masked,
    output logic              irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask <= '1;
        else        mask <= (mask & ~mclr_bits) | mset_bits;
    end

    always_comb begin
        masked = flags & ~mask;
        irq    = |masked;
    end

    // R6
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|mset_bits) |=> ((mask & $past(mset_bits)) == $past(mset_bits)));
    // R6
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(mclr_bits & ~mset_bits)) |=> ((mask & $past(mclr_bits & ~mset_bits)) == '0));
endmodule

// File: rtl/dbl_ack_fsm.sv
module dbl_ack_fsm
    import dbl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raise,
    input  logic ack_clr,
    input  logic ack_en,
    output logic status,
    output logic irq
);
    ack_state_e state, state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ACK_IDLE:   if (raise) state_nxt = ACK_RAISED;
            ACK_RAISED: if (ack_clr && !raise) state_nxt = ACK_IDLE;
            default:    state_nxt = ACK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ACK_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        status = (state == ACK_RAISED);
        irq    = status & ack_en;
    end

    // R8
    ack_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        raise |=> status);
    // R9
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_clr && !raise) |=> !status);
endmodule

// File: rtl/doorbell_window.sv
module doorbell_window
    import dbl_pkg::*;
#(
    parameter int FLAG_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_wen,
    input  logic [2:0]        tx_addr,
    input  logic [FLAG_W-1:0] tx_wdata,
    output logic [FLAG_W-1:0] tx_rdata,
    output logic              tx_irq,
    output logic              tx_comb_irq,
    input  logic              rx_wen,
    input  logic [2:0]        rx_addr,
    input  logic [FLAG_W-1:0] rx_wdata,
    output logic [FLAG_W-1:0] rx_rdata,
    output logic              rx_irq,
    output logic              rx_comb_irq
);
    localparam logic [FLAG_W-1:0] ZERO = '0;

    logic [FLAG_W-1:0] set_bits, clr_bits, mset_bits, mclr_bits;
    logic [FLAG_W-1:0] flags, mask, masked;
    logic              any_dropped, ack_status, ack_clr;
    logic              ack_en, tx_cmb_en, rx_cmb_en;

    always_comb begin
        set_bits  = (tx_wen && tx_addr == TX_SET)  ? tx_wdata : ZERO;
        clr_bits  = (rx_wen && rx_addr == RX_CLR)  ? rx_wdata : ZERO;
        mset_bits = (rx_wen && rx_addr == RX_MSET) ? rx_wdata : ZERO;
        mclr_bits = (rx_wen && rx_addr == RX_MCLR) ? rx_wdata : ZERO;
        ack_clr   = tx_wen && tx_addr == TX_ACK_CLR && tx_wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_en    <= 1'b0;
            tx_cmb_en <= 1'b0;
            rx_cmb_en <= 1'b0;
        end else begin
            if (tx_wen && tx_addr == TX_ACK_EN) ack_en    <= tx_wdata[0];
            if (tx_wen && tx_addr == TX_CTRL)   tx_cmb_en <= tx_wdata[0];
            if (rx_wen && rx_addr == RX_CTRL)   rx_cmb_en <= rx_wdata[0];
        end
    end

    dbl_flag_store #(.FLAG_W(FLAG_W)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_bits(set_bits), .clr_bits(clr_bits),
        .flags(flags), .any_dropped(any_dropped)
    );

    dbl_rx_mask #(.FLAG_W(FLAG_W)) u_mask (
        .clk(clk), .rst_n(rst_n), .mset_bits(mset_bits), .mclr_bits(mclr_bits),
        .flags(flags), .mask(mask), .masked(masked), .irq(rx_irq)
    );

    dbl_ack_fsm u_ack (
        .clk(clk), .rst_n(rst_n), .raise(any_dropped), .ack_clr(ack_clr),
        .ack_en(ack_en), .status(ack_status), .irq(tx_irq)
    );

    always_comb begin
        tx_rdata = ZERO;
        case (tx_addr)
            TX_STAT:   tx_rdata = flags;
            TX_ACK_ST: tx_rdata = {{(FLAG_W-1){1'b0}}, ack_status};
            TX_ACK_EN: tx_rdata = {{(FLAG_W-1){1'b0}}, ack_en};
            TX_CTRL:   tx_rdata = {{(FLAG_W-1){1'b0}}, tx_cmb_en};
            default:   tx_rdata = ZERO;
        endcase
    end

    always_comb begin
        rx_rdata = ZERO;
        case (rx_addr)
            RX_STAT:  rx_rdata = flags;
            RX_MSTAT: rx_rdata = masked;
            RX_MASK:  rx_rdata = mask;
            RX_CTRL:  rx_rdata = {{(FLAG_W-1){1'b0}}, rx_cmb_en};
            default:  rx_rdata = ZERO;
        endcase
    end

    assign tx_comb_irq = tx_irq & tx_cmb_en;
    assign rx_comb_irq = rx_irq & rx_cmb_en;

    // R10
    tx_irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> (ack_en && ack_status));
    // R11
    rx_comb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_comb_irq |-> (rx_cmb_en && (|masked)));
    // R11
    tx_comb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_comb_irq |-> (tx_cmb_en && tx_irq));
endmodule

// File: tb/test_doorbell_window.sv
`timescale 1ns/1ps
module test_doorbell_window;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_wen = 1'b0, rx_wen = 1'b0;
    logic [2:0]  tx_addr = '0, rx_addr = '0;
    logic [31:0] tx_wdata = '0, rx_wdata = '0;
    logic [31:0] tx_rdata, rx_rdata;
    logic        tx_irq, tx_comb_irq, rx_irq, rx_comb_irq;
    int          errors = 0;
    int          checks = 0;

    always #2 clk = ~clk;

    doorbell_window i_doorbell_window (
        .clk(clk), .rst_n(rst_n),
        .tx_wen(tx_wen), .tx_addr(tx_addr), .tx_wdata(tx_wdata), .tx_rdata(tx_rdata),
        .tx_irq(tx_irq), .tx_comb_irq(tx_comb_irq),
        .rx_wen(rx_wen), .rx_addr(rx_addr), .rx_wdata(rx_wdata), .rx_rdata(rx_rdata),
        .rx_irq(rx_irq), .rx_comb_irq(rx_comb_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cycle(input logic tw, input logic [2:0] ta, input logic [31:0] td,
                         input logic rw, input logic [2:0] ra, input logic [31:0] rd);
        @(negedge clk);
        tx_wen = tw; tx_addr = ta; tx_wdata = td;
        rx_wen = rw; rx_addr = ra; rx_wdata = rd;
        @(posedge clk);
        #1;
        tx_wen = 1'b0; rx_wen = 1'b0;
    endtask

    task automatic txw(input logic [2:0] a, input logic [31:0] d);
        cycle(1'b1, a, d, 1'b0, 3'd0, 32'h0);
    endtask

    task automatic rxw(input logic [2:0] a, input logic [31:0] d);
        cycle(1'b0, 3'd0, 32'h0, 1'b1, a, d);
    endtask

    task automatic txr(input string req, input logic [2:0] a, input logic [31:0] exp);
        @(negedge clk);
        tx_addr = a;
        #1;
        chk(req, tx_rdata, exp);
    endtask

    task automatic rxr(input string req, input logic [2:0] a, input logic [31:0] exp);
        @(negedge clk);
        rx_addr = a;
        #1;
        chk(req, rx_rdata, exp);
    endtask

    task automatic t_reset;
        txr("R1 flags", 3'd0, 32'h0);
        rxr("R1 mask", 3'd3, 32'hFFFF_FFFF);
        txr("R1 ack status", 3'd2, 32'h0);
        txr("R1 ack enable", 3'd4, 32'h0);
        txr("R1 tx ctrl", 3'd5, 32'h0);
        rxr("R1 rx ctrl", 3'd6, 32'h0);
        chk("R1 irqs", {28'h0, tx_irq, tx_comb_irq, rx_irq, rx_comb_irq}, 32'h0);
    endtask

    task automatic t_set;
        txw(3'd1, 32'hA5A5_0001);
        txr("R2 set", 3'd0, 32'hA5A5_0001);
        txw(3'd1, 32'h0000_0100);
        txr("R2 set keeps others", 3'd0, 32'hA5A5_0101);
        rxr("R3 receiver status", 3'd0, 32'hA5A5_0101);
    endtask

    task automatic t_mask;
        chk("R7 all masked irq", {31'h0, rx_irq}, 32'h0);
        rxw(3'd5, 32'h0000_0101);
        rxr("R6 mask clear", 3'd3, 32'hFFFF_FEFE);
        rxr("R7 masked status", 3'd1, 32'h0000_0101);
        chk("R7 irq on", {31'h0, rx_irq}, 32'h1);
        rxw(3'd4, 32'h0000_0001);
        rxr("R6 mask set", 3'd3, 32'hFFFF_FEFF);
        rxr("R7 masked after set", 3'd1, 32'h0000_0100);
    endtask

    task automatic t_clear;
        rxw(3'd2, 32'h0000_0001);
        txr("R4 clear", 3'd0, 32'hA5A5_0100);
        txr("R8 ack raised", 3'd2, 32'h1);
        chk("R10 irq disabled", {31'h0, tx_irq}, 32'h0);
        txw(3'd3, 32'h1);
        txr("R9 ack cleared", 3'd2, 32'h0);
        rxw(3'd2, 32'h0000_0002);
        txr("R8 no ack on idle flag", 3'd2, 32'h0);
        txr("R4 idle clear no change", 3'd0, 32'hA5A5_0100);
    endtask

    task automatic t_enable;
        txw(3'd4, 32'h1);
        txr("R10 enable readback", 3'd4, 32'h1);
        rxw(3'd2, 32'h0000_0100);
        chk("R10 irq on", {31'h0, tx_irq}, 32'h1);
        chk("R7 irq off after clear", {31'h0, rx_irq}, 32'h0);
        txw(3'd3, 32'h1);
        chk("R10 irq off", {31'h0, tx_irq}, 32'h0);
    endtask

    task automatic t_collision;
        txw(3'd1, 32'h0000_0002);
        cycle(1'b1, 3'd1, 32'h0000_0002, 1'b1, 3'd2, 32'h0000_0002);
        txr("R5 set wins", 3'd0, 32'hA5A5_0002);
        txr("R5 no ack", 3'd2, 32'h0);
    endtask

    task automatic t_race;
        rxw(3'd2, 32'h0000_0002);
        txr("R8 ack again", 3'd2, 32'h1);
        cycle(1'b1, 3'd3, 32'h1, 1'b1, 3'd2, 32'h0001_0000);
        txr("R9 raise beats clear", 3'd2, 32'h1);
        txr("R4 bit16 cleared", 3'd0, 32'hA5A4_0000);
    endtask

    task automatic t_combine;
        rxw(3'd5, 32'hFFFF_FFFF);
        chk("R11 rx comb gated", {30'h0, rx_irq, rx_comb_irq}, 32'h2);
        rxw(3'd6, 32'h1);
        rxr("R11 rx ctrl readback", 3'd6, 32'h1);
        chk("R11 rx comb on", {31'h0, rx_comb_irq}, 32'h1);
        chk("R11 tx comb gated", {30'h0, tx_irq, tx_comb_irq}, 32'h2);
        txw(3'd5, 32'h1);
        txr("R11 tx ctrl readback", 3'd5, 32'h1);
        chk("R11 tx comb on", {31'h0, tx_comb_irq}, 32'h1);
        rxw(3'd2, 32'hFFFF_FFFF);
        rxr("R4 clear all", 3'd0, 32'h0);
        chk("R7 irq off", {31'h0, rx_irq}, 32'h0);
    endtask

    initial begin
        #20000;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_set;
        t_mask;
        t_clear;
        t_enable;
        t_collision;
        t_race;
        t_combine;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule